// File: doc/BRIEF.md
# Tamper Response Controller

This block sits between the tamper detectors of a chip and the secrets those detectors guard. It takes single-cycle event pulses from five external and four internal tamper sources. For every enabled source it keeps a sticky flag. Each source is set up for one of two kinds of handling:

- **Confirmed handling** wipes a bank of nine 32-bit backup registers at once.
- **Potential handling** keeps the contents but blocks all access to them until software clears the flag.

Software can also block access or start a wipe directly. Each of the first three external sources has a mask that lets its event drive a trigger output without leaving a flag behind.

Software uses a simple word-addressed register bus. Through it, software sets enables, handling modes, masks and interrupt enables, reads raw and masked status, clears flags by writing 1, and reads or writes the backup words. A synchronous write-permit input gates every write. The outputs are all registered and are driven to other blocks:

- the triggers
- a one-cycle event pulse
- the potential (block) level
- the confirmed (erase) level
- the interrupt

Top module: `tamper_guard`

## Requirements
- R1: A flagged source whose handling bit is 0 (confirmed) drives confirmed_o high on the second rising edge after its event pulse, and the backup registers read 0 from then on.
- R2: A flagged source whose handling bit is 1 (potential) drives potential_o high on the second edge after its event, without asserting confirmed_o. While the flag stays set, backup reads return 0 and backup writes are dropped. Once the flag is cleared, the earlier contents read back unchanged.
- R3: The backup registers can be accessed only while the block bit (offset 0x04 bit 22) is 0 and no flag is set. A blocked read returns 0 and a blocked write is dropped. The block bit also drives potential_o high one cycle after it is written.
- R4: Writing 1 to offset 0x04 bit 23 clears all backup registers and raises confirmed_o for one cycle, two edges after the write. The bit always reads back 0, and writing 0 to it has no effect.
- R5: A backup register stays at zero while any confirmed-handling flag is set. It still reads 0 after that flag is cleared, until it is written again.
- R6: A flag stays set until software writes 1 to its bit at offset 0x3C. While the flag is set, further events on that source produce no trigger pulse, no event pulse and no new flag.
- R7: When mask bit 16+k of offset 0x04 is set (k = 0..2, external source k), an event on source k pulses trig_o[k]. The flag stays 0, and nothing is wiped or blocked.
- R8: irq_o is high one edge after any flag is set together with its enable bit at offset 0x2C. Offset 0x34 reads the per-source AND of flag and enable.
- R9: The register offsets are: 0x00 enables, 0x04 control, 0x08 internal handling bits, 0x0C 8-bit filter setting, 0x2C interrupt enables, 0x30 status, 0x34 masked status, 0x3C clear, and 0x100+4x for backup word x (x = 0..8). In source-indexed words, external source k is bit k and internal source j is bit 18+j. In control, bits 0..4 are the external handling bits and bits 24..28 are stored polarity bits. At 0x08, internal source j's handling bit is bit 2+j.
- R10: evt_o pulses for one cycle on the edge that sets a new flag, whatever the handling of that source.
- R11: While wr_allow is 0, no register or backup word changes on a bus write.
- R12: An event on a source whose enable bit is 0 has no effect.
- R13: bus_rdata holds the read data one edge after bus_rd. Unmapped offsets and all registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| ext_evt | input | 5 | External tamper event pulses |
| int_evt | input | 4 | Internal tamper event pulses |
| wr_allow | input | 1 | Write permit for every bus write |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig_o | output | 5 | Per-external-source trigger pulses |
| evt_o | output | 1 | New-flag event pulse |
| potential_o | output | 1 | Secret access blocked level |
| confirmed_o | output | 1 | Secret erase level |
| irq_o | output | 1 | Interrupt |

## Verification
A flag bit that is wrong inside the block shows up at the ports within two edges:

- potential_o or confirmed_o takes the wrong level.
- irq_o takes the wrong level.
- A repeat event produces a trigger pulse that should not be there.

A wrong access-permission state appears on the very next read: a backup word either comes back as zero or leaks its contents. A missed wipe or a dropped write shows up only on a later read of that backup word. The vectors therefore read every touched word after each change of tamper state.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam logic [11:0] OFS_EN    = 12'h000;
  localparam logic [11:0] OFS_CTL   = 12'h004;
  localparam logic [11:0] OFS_IPOM  = 12'h008;
  localparam logic [11:0] OFS_FILT  = 12'h00C;
  localparam logic [11:0] OFS_IE    = 12'h02C;
  localparam logic [11:0] OFS_STAT  = 12'h030;
  localparam logic [11:0] OFS_MSTAT = 12'h034;
  localparam logic [11:0] OFS_CLR   = 12'h03C;
  localparam logic [11:0] OFS_BKP   = 12'h100;

  localparam int ERASE_BIT = 23;
  localparam int BLOCK_BIT = 22;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_EN, SEL_CTL, SEL_IPOM, SEL_FILT,
    SEL_IE, SEL_STAT, SEL_MSTAT, SEL_CLR
  } csr_sel_e;

  // bit position of source s inside a source-indexed register word
  function automatic int src_pos(input int s, input int n_ext, input int int_lsb);
    return (s < n_ext) ? s : int_lsb + s - n_ext;
  endfunction
endpackage

// File: rtl/tg_regfile.sv
module tg_regfile import tg_pkg::*; #(
  parameter int N_EXT    = 5,
  parameter int N_INT    = 4,
  parameter int N_MSK    = 3,
  parameter int NS       = N_EXT + N_INT,
  parameter int INT_LSB  = 18,
  parameter int IPOM_LSB = 2,
  parameter int POL_LSB  = 24,
  parameter int MSK_LSB  = 16,
  parameter int FILT_W   = 8,
  parameter int AW       = 12,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          wr_allow,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [NS-1:0] flags,
  output logic [NS-1:0] src_en,
  output logic [NS-1:0] pot_mode,
  output logic [NS-1:0] irq_en,
  output logic [NS-1:0] mask_src,
  output logic          sw_block,
  output logic          erase_req,
  output logic [NS-1:0] clr_req,
  output logic [DW-1:0] csr_rdata
);
  csr_sel_e sel;
  logic wr_ok;
  logic [NS-1:0] wd_src;
  logic [NS-1:0] en_q, pom_q, ie_q;
  logic [N_MSK-1:0] msk_q;
  logic [N_EXT-1:0] pol_q;
  logic blk_q, erase_q;
  logic [FILT_W-1:0] filt_q;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_ok = bus_wr & wr_allow;

  always_comb begin
    case (bus_addr)
      AW'(OFS_EN):    sel = SEL_EN;
      AW'(OFS_CTL):   sel = SEL_CTL;
      AW'(OFS_IPOM):  sel = SEL_IPOM;
      AW'(OFS_FILT):  sel = SEL_FILT;
      AW'(OFS_IE):    sel = SEL_IE;
      AW'(OFS_STAT):  sel = SEL_STAT;
      AW'(OFS_MSTAT): sel = SEL_MSTAT;
      AW'(OFS_CLR):   sel = SEL_CLR;
      default:        sel = SEL_NONE;
    endcase
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      wd_src[s]  = bus_wdata[src_pos(s, N_EXT, INT_LSB)];
      clr_req[s] = wr_ok && (sel == SEL_CLR) && bus_wdata[src_pos(s, N_EXT, INT_LSB)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pom_q   <= '0;
      ie_q    <= '0;
      msk_q   <= '0;
      pol_q   <= '0;
      blk_q   <= 1'b0;
      filt_q  <= '0;
      erase_q <= 1'b0;
    end else begin
      erase_q <= wr_ok && (sel == SEL_CTL) && bus_wdata[ERASE_BIT];
      if (wr_ok) begin
        case (sel)
          SEL_EN:   en_q <= wd_src;
          SEL_CTL: begin
            pom_q[N_EXT-1:0] <= bus_wdata[N_EXT-1:0];
            blk_q <= bus_wdata[BLOCK_BIT];
            msk_q <= bus_wdata[MSK_LSB +: N_MSK];
            pol_q <= bus_wdata[POL_LSB +: N_EXT];
          end
          SEL_IPOM: pom_q[NS-1:N_EXT] <= bus_wdata[IPOM_LSB +: N_INT];
          SEL_FILT: filt_q <= bus_wdata[FILT_W-1:0];
          SEL_IE:   ie_q <= wd_src;
          default:  ;
        endcase
      end
    end
  end

  generate
    for (genvar s = 0; s < NS; s++) begin : g_mask
      if (s < N_MSK) begin : g_has
        assign mask_src[s] = msk_q[s];
      end else begin : g_none
        assign mask_src[s] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    csr_rdata = '0;
    case (sel)
      SEL_EN:
        for (int s = 0; s < NS; s++) csr_rdata[src_pos(s, N_EXT, INT_LSB)] = en_q[s];
      SEL_CTL: begin
        csr_rdata[N_EXT-1:0]         = pom_q[N_EXT-1:0];
        csr_rdata[MSK_LSB +: N_MSK]  = msk_q;
        csr_rdata[BLOCK_BIT]         = blk_q;
        csr_rdata[POL_LSB +: N_EXT]  = pol_q;
      end
      SEL_IPOM: csr_rdata[IPOM_LSB +: N_INT] = pom_q[NS-1:N_EXT];
      SEL_FILT: csr_rdata[FILT_W-1:0] = filt_q;
      SEL_IE:
        for (int s = 0; s < NS; s++) csr_rdata[src_pos(s, N_EXT, INT_LSB)] = ie_q[s];
      SEL_STAT:
        for (int s = 0; s < NS; s++) csr_rdata[src_pos(s, N_EXT, INT_LSB)] = flags[s];
      SEL_MSTAT:
        for (int s = 0; s < NS; s++) csr_rdata[src_pos(s, N_EXT, INT_LSB)] = flags[s] & ie_q[s];
      default: ;
    endcase
  end

  assign src_en    = en_q;
  assign pot_mode  = pom_q;
  assign irq_en    = ie_q;
  assign sw_block  = blk_q;
  assign erase_req = erase_q;

  // R4: an erase request only follows a permitted bus write
  p_erase_from_write_r4: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> $past(bus_wr && wr_allow));
  // R11: configuration is frozen without a permitted write
  p_write_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && wr_allow) |=> $stable({en_q, pom_q, ie_q, msk_q, pol_q, blk_q, filt_q}));
endmodule

// File: rtl/tg_flag_bank.sv
module tg_flag_bank #(
  parameter int N_EXT = 5,
  parameter int NS    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    evt,
  input  logic [NS-1:0]    src_en,
  input  logic [NS-1:0]    mask_src,
  input  logic [NS-1:0]    clr_req,
  output logic [NS-1:0]    flags,
  output logic [N_EXT-1:0] trig,
  output logic             evt_pulse
);
  logic [NS-1:0] flag_q, accept, set_f;
  logic [N_EXT-1:0] trig_q;
  logic evt_q;

  // an event is taken only on an enabled source whose flag is clear
  assign accept = evt & src_en & ~flag_q;
  assign set_f  = accept & ~mask_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      trig_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      flag_q <= ((flag_q & ~clr_req) | set_f) & ~mask_src;
      trig_q <= accept[N_EXT-1:0];
      evt_q  <= |set_f;
    end
  end

  assign flags     = flag_q;
  assign trig      = trig_q;
  assign evt_pulse = evt_q;

  generate
    for (genvar s = 0; s < NS; s++) begin : g_chk
      // R6: a flag holds until cleared
      p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q[s] && !clr_req[s] && !mask_src[s]) |=> flag_q[s]);
      // R7: a masked source never keeps a flag
      p_mask_clears_r7: assert property (@(posedge clk) disable iff (rst)
        mask_src[s] |=> !flag_q[s]);
    end
  endgenerate

  // R10: the event pulse coincides with a newly raised flag
  p_evt_on_new_flag_r10: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> (|(flag_q & ~$past(flag_q))));
endmodule

// File: rtl/tg_backup_store.sv
module tg_backup_store import tg_pkg::*; #(
  parameter int N_BKP = 9,
  parameter int DW    = 32,
  parameter int AW    = 12,
  parameter int IW    = $clog2(N_BKP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          wr_allow,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          access_ok,
  input  logic          wipe,
  output logic          hit,
  output logic [DW-1:0] rdata
);
  logic [N_BKP-1:0][DW-1:0] mem;
  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic any_nz;

  assign off = bus_addr - AW'(OFS_BKP);
  assign hit = (bus_addr >= AW'(OFS_BKP)) && (off < AW'(4 * N_BKP)) && (off[1:0] == 2'b00);
  assign idx = off[IW+1:2];

  always_ff @(posedge clk) begin
    if (rst || wipe) mem <= '0;
    else if (bus_wr && wr_allow && hit && access_ok) mem[idx] <= bus_wdata;
  end

  assign rdata = (hit && access_ok) ? mem[idx] : '0;

  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < N_BKP; i++) any_nz = any_nz | (|mem[i]);
  end

  // R5: a wipe leaves every word at zero
  p_wipe_zero_r5: assert property (@(posedge clk) disable iff (rst)
    wipe |=> !any_nz);
  // R3: no word changes while access is blocked
  p_blocked_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!access_ok && !wipe) |=> $stable(mem));
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard import tg_pkg::*; #(
  parameter int N_EXT = 5,
  parameter int N_INT = 4,
  parameter int N_MSK = 3,
  parameter int N_BKP = 9,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic [N_INT-1:0] int_evt,
  input  logic             wr_allow,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [N_EXT-1:0] trig_o,
  output logic             evt_o,
  output logic             potential_o,
  output logic             confirmed_o,
  output logic             irq_o
);
  localparam int NS = N_EXT + N_INT;

  logic [NS-1:0] flags, src_en, pot_mode, irq_en, mask_src, clr_req;
  logic sw_block, erase_req, bkp_hit;
  logic [DW-1:0] csr_rdata, bkp_rdata, rdata_q;
  logic conf_level, pot_level, access_ok, wipe;
  logic conf_q, pot_q, irq_q;

  tg_regfile #(
    .N_EXT(N_EXT), .N_INT(N_INT), .N_MSK(N_MSK), .NS(NS), .AW(AW), .DW(DW)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .wr_allow(wr_allow),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flags),
    .src_en(src_en), .pot_mode(pot_mode), .irq_en(irq_en), .mask_src(mask_src),
    .sw_block(sw_block), .erase_req(erase_req), .clr_req(clr_req),
    .csr_rdata(csr_rdata)
  );

  tg_flag_bank #(.N_EXT(N_EXT), .NS(NS)) flags_i (
    .clk(clk), .rst(rst), .evt({int_evt, ext_evt}), .src_en(src_en),
    .mask_src(mask_src), .clr_req(clr_req), .flags(flags),
    .trig(trig_o), .evt_pulse(evt_o)
  );

  assign conf_level = |(flags & ~pot_mode);
  assign pot_level  = (|(flags & pot_mode)) | sw_block;
  assign access_ok  = !sw_block && !(|flags);
  assign wipe       = conf_level | erase_req;

  tg_backup_store #(.N_BKP(N_BKP), .DW(DW), .AW(AW)) bkp_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .wr_allow(wr_allow),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .access_ok(access_ok),
    .wipe(wipe), .hit(bkp_hit), .rdata(bkp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_q  <= 1'b0;
      pot_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      conf_q <= wipe;
      pot_q  <= pot_level;
      irq_q  <= |(flags & irq_en);
      if (bus_rd) rdata_q <= bkp_hit ? bkp_rdata : csr_rdata;
    end
  end

  assign confirmed_o = conf_q;
  assign potential_o = pot_q;
  assign irq_o       = irq_q;
  assign bus_rdata   = rdata_q;

  // R1: a confirmed-handling flag raises the erase output next edge
  p_confirmed_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ~pot_mode)) |=> confirmed_o);
  // R8: an enabled flag raises the interrupt next edge
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (|(flags & irq_en)) |=> irq_o);
  // R2: a potential-handling flag alone never erases
  p_potential_no_erase_r2: assert property (@(posedge clk) disable iff (rst)
    ((|(flags & pot_mode)) && !(|(flags & ~pot_mode)) && !erase_req) |=> !confirmed_o);
endmodule

// File: tb/tamper_guard_tb_top.sv
module tamper_guard_tb_top;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_PT = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic [1:0] op, input logic [11:0] addr,
                              input logic [31:0] data, input logic [31:0] exp,
                              input logic [7:0] req);
    mk = '{op: op, addr: addr, data: data, exp: exp, req: req};
  endfunction

  // port snapshot for OP_PT: [4:0] trig, [5] evt, [6] potential, [7] confirmed, [8] irq
  localparam int NV = 61;
  localparam vec_t VECS [NV] = '{
    mk(OP_WR, 12'h000, 32'h003C001F, 32'h0, 8'd9),
    mk(OP_RD, 12'h000, 32'h0, 32'h003C001F, 8'd9),   // R9 enable layout
    mk(OP_WR, 12'h100, 32'hA5A50001, 32'h0, 8'd3),
    mk(OP_WR, 12'h120, 32'h12345678, 32'h0, 8'd3),
    mk(OP_RD, 12'h100, 32'h0, 32'hA5A50001, 8'd3),   // R3 open access
    mk(OP_RD, 12'h120, 32'h0, 32'h12345678, 8'd3),
    mk(OP_WR, 12'h004, 32'h00000002, 32'h0, 8'd9),
    mk(OP_RD, 12'h004, 32'h0, 32'h00000002, 8'd9),
    mk(OP_WR, 12'h02C, 32'h00000002, 32'h0, 8'd8),
    mk(OP_EV, 12'h000, 32'h00000002, 32'h0, 8'd2),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000162, 8'd2),   // R2 potential
    mk(OP_RD, 12'h030, 32'h0, 32'h00000002, 8'd6),
    mk(OP_RD, 12'h034, 32'h0, 32'h00000002, 8'd8),   // R8 masked status
    mk(OP_RD, 12'h02C, 32'h0, 32'h00000002, 8'd8),
    mk(OP_RD, 12'h100, 32'h0, 32'h0, 8'd2),
    mk(OP_WR, 12'h100, 32'h0000FFFF, 32'h0, 8'd2),
    mk(OP_EV, 12'h000, 32'h00000002, 32'h0, 8'd6),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000140, 8'd6),   // R6 no re-flag
    mk(OP_WR, 12'h03C, 32'h00000002, 32'h0, 8'd6),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000000, 8'd6),
    mk(OP_RD, 12'h030, 32'h0, 32'h0, 8'd6),
    mk(OP_RD, 12'h100, 32'h0, 32'hA5A50001, 8'd2),   // R2 retained
    mk(OP_EV, 12'h000, 32'h00100000, 32'h0, 8'd1),
    mk(OP_PT, 12'h000, 32'h0, 32'h000000A0, 8'd1),   // R1 confirmed
    mk(OP_RD, 12'h030, 32'h0, 32'h00100000, 8'd1),
    mk(OP_RD, 12'h034, 32'h0, 32'h0, 8'd8),
    mk(OP_WR, 12'h03C, 32'h00100000, 32'h0, 8'd6),
    mk(OP_RD, 12'h100, 32'h0, 32'h0, 8'd5),          // R5 wiped
    mk(OP_RD, 12'h120, 32'h0, 32'h0, 8'd5),
    mk(OP_WR, 12'h100, 32'h00000077, 32'h0, 8'd3),
    mk(OP_RD, 12'h100, 32'h0, 32'h00000077, 8'd3),
    mk(OP_WR, 12'h004, 32'h00800002, 32'h0, 8'd4),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000080, 8'd4),   // R4 erase pulse
    mk(OP_RD, 12'h100, 32'h0, 32'h0, 8'd4),
    mk(OP_RD, 12'h004, 32'h0, 32'h00000002, 8'd4),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000000, 8'd4),
    mk(OP_WR, 12'h004, 32'h00400002, 32'h0, 8'd3),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000040, 8'd3),   // R3 block bit
    mk(OP_WR, 12'h120, 32'h00000009, 32'h0, 8'd3),
    mk(OP_RD, 12'h120, 32'h0, 32'h0, 8'd3),
    mk(OP_WR, 12'h004, 32'h00000002, 32'h0, 8'd3),
    mk(OP_RD, 12'h120, 32'h0, 32'h0, 8'd3),
    mk(OP_WR, 12'h004, 32'h00010002, 32'h0, 8'd7),
    mk(OP_WR, 12'h104, 32'h00000055, 32'h0, 8'd7),
    mk(OP_EV, 12'h000, 32'h00000001, 32'h0, 8'd7),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000001, 8'd7),   // R7 masked trigger
    mk(OP_RD, 12'h030, 32'h0, 32'h0, 8'd7),
    mk(OP_RD, 12'h104, 32'h0, 32'h00000055, 8'd7),
    mk(OP_WR, 12'h000, 32'h003C0017, 32'h0, 8'd12),
    mk(OP_EV, 12'h000, 32'h00000008, 32'h0, 8'd12),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000000, 8'd12),  // R12 disabled
    mk(OP_RD, 12'h030, 32'h0, 32'h0, 8'd12),
    mk(OP_WR, 12'h008, 32'h00000004, 32'h0, 8'd9),
    mk(OP_RD, 12'h008, 32'h0, 32'h00000004, 8'd9),
    mk(OP_EV, 12'h000, 32'h00040000, 32'h0, 8'd10),
    mk(OP_PT, 12'h000, 32'h0, 32'h00000060, 8'd10),  // R10 event pulse
    mk(OP_RD, 12'h104, 32'h0, 32'h0, 8'd2),
    mk(OP_WR, 12'h03C, 32'h00040000, 32'h0, 8'd6),
    mk(OP_RD, 12'h104, 32'h0, 32'h00000055, 8'd2),
    mk(OP_WR, 12'h00C, 32'h0000007B, 32'h0, 8'd9),
    mk(OP_RD, 12'h00C, 32'h0, 32'h0000007B, 8'd9)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] ext_evt = '0;
  logic [3:0] int_evt = '0;
  logic wr_allow = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0] trig_o;
  logic evt_o, potential_o, confirmed_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [4:0] cap_trig;
  logic cap_evt;
  logic [31:0] rd_val;

  always #10 clk = ~clk;

  tamper_guard dut_i (
    .clk(clk), .rst(rst), .ext_evt(ext_evt), .int_evt(int_evt),
    .wr_allow(wr_allow), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_o(trig_o), .evt_o(evt_o), .potential_o(potential_o),
    .confirmed_o(confirmed_o), .irq_o(irq_o)
  );

  task automatic check(input int req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    cap_trig = trig_o; cap_evt = evt_o;
    @(negedge clk);
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    cap_trig = trig_o; cap_evt = evt_o;
    d = bus_rdata;
  endtask

  task automatic do_ev(input logic [31:0] d);
    ext_evt = d[4:0]; int_evt = d[21:18];
    @(negedge clk);
    ext_evt = '0; int_evt = '0;
    cap_trig = trig_o; cap_evt = evt_o;
    @(negedge clk);
  endtask

  function automatic logic [31:0] snap();
    snap = {23'd0, irq_o, confirmed_o, potential_o, cap_evt, cap_trig};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    cap_trig = trig_o; cap_evt = evt_o;
    check(13, "ports after reset", snap(), 32'h0);
    do_rd(12'h000, rd_val); check(13, "enables after reset", rd_val, 32'h0);
    do_rd(12'h030, rd_val); check(13, "status after reset", rd_val, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: do_wr(VECS[i].addr, VECS[i].data);
        OP_RD: begin
          do_rd(VECS[i].addr, rd_val);
          check(int'(VECS[i].req), $sformatf("vector %0d read %h", i, VECS[i].addr),
                rd_val, VECS[i].exp);
        end
        OP_EV: do_ev(VECS[i].data);
        default: check(int'(VECS[i].req), $sformatf("vector %0d ports", i),
                       snap(), VECS[i].exp);
      endcase
    end

    // R11 write permit low: writes dropped
    wr_allow = 1'b0;
    do_wr(12'h000, 32'h0);
    do_wr(12'h104, 32'h0000DEAD);
    do_wr(12'h004, 32'h00800000);
    wr_allow = 1'b1;
    do_rd(12'h000, rd_val); check(11, "enables under write lock", rd_val, 32'h003C0017);
    do_rd(12'h104, rd_val); check(11, "backup under write lock", rd_val, 32'h00000055);
    check(11, "no erase under write lock", {31'd0, confirmed_o}, 32'h0);

    // R13 unmapped and misaligned reads
    do_rd(12'h200, rd_val); check(13, "unmapped read", rd_val, 32'h0);
    do_rd(12'h102, rd_val); check(13, "misaligned backup read", rd_val, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule